// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Trellis Unit

This block is the path-metric engine of a Viterbi decoder for a rate-1/2 convolutional code with constraint length 7, so the trellis has 64 states. Each clock it accepts one trellis stage: four branch metrics, one for each possible pair of code bits. For every state it adds each incoming branch's metric to the path metric of that branch's source state and keeps the smaller sum. It then reports, for every state, which of the two predecessors survived. The 64-bit decision vector goes to a separate traceback block. Branch metrics arrive from a separate front end. A lower metric means a better match.

Path metrics wrap freely in modular arithmetic. Comparisons take the sign of the difference, so no subtraction pass is ever needed. A synchronous restart input `srst` ties the trellis to the all-zero state on both sides of the clock edge where it is sampled high. The stage that arrives together with the pulse may only end in state zero. This is burst tail termination. The stage that follows the pulse may only leave state zero. This is burst start. Bursts can therefore run back to back, and continuous streams need no restart at all.

A small controller has two named phases:
- `ST_START`: metrics have just been cleared, and the next stage may only leave state zero.
- `ST_RUN`: normal unrestricted operation.

Its transitions are:
- Any phase goes to `ST_START` whenever `srst` is sampled high.
- `ST_START` goes to `ST_RUN` on the first stage accepted with `srst` low.
- Otherwise the phase holds.

Top module: `vit_acs_trellis`

## Requirements
- R1: A state number holds the last 6 input bits, with the newest in bit 5.
  - The branch from predecessor p with input u forms the 7-bit register {u,p}.
  - Code bit c0 is the parity of that register masked with octal 171, and c1 is the parity masked with octal 133.
  - The branch uses the metric at symbol index c0*2+c1. That metric sits in `bm_i[idx*4 +: 4]`.
- R2: For each state s, the predecessors are {s[4:0],0} and {s[4:0],1}. Bit s of `dec_o` is 1 exactly when the second predecessor gives a strictly smaller sum of path metric plus branch metric. On a tie the bit is 0.
- R3: Decisions stay correct over streams of any length, including streams whose accumulated metrics far exceed the metric register range.
- R4: `dec_o` and `dec_valid_o` update on the edge that samples `sym_valid`, so they appear one cycle after the stage's inputs. `dec_valid_o` is low in the cycle after `sym_valid` was low.
- R5: A cycle with `sym_valid` low and `srst` low leaves the path metrics untouched, whatever `bm_i` carries. Later stages decode as if that cycle never happened.
- R6: After `srst` is sampled high, the next accepted stage may only use branches leaving state zero. All other branches lose. That stage's decision vector is all zeros.
- R7: A stage accepted together with `srst` high may only use branches entering state zero. Bits 63..1 of its decision vector are 0, and bit 0 follows R2.
- R8: After a cycle with `srst` high and `sym_valid` low, `dec_valid_o` is low.
- R9: Restart pulses may end one burst and begin the next in consecutive cycles. Without any pulse, the unit decodes continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| srst | input | 1 | Synchronous trellis restart; ends the current stage at, and starts the next from, state zero |
| sym_valid | input | 1 | The branch metrics on `bm_i` form a trellis stage |
| bm_i | input | 16 | Four 4-bit branch metrics, indexed by c0*2+c1 |
| dec_o | output | 64 | Survivor decision per state (1 = odd predecessor won) |
| dec_valid_o | output | 1 | `dec_o` holds a fresh stage |

## Verification
- **Noiseless codeword metrics.** These give one clear winner per state. They show whether the branch-to-symbol mapping and the predecessor indexing are right.
- **Uniformly random metrics.** These produce many near-ties. They separate a strict comparison from a non-strict one, and expose any misrouted metric slice.
- **Uniformly high metrics over long runs.** These force the path metrics to wrap many times, which exposes a faulty wrap-around comparison.
- **Restart pulses, gaps and back-to-back bursts.** These are placed at the start of a burst, inside it and at its tail. They show whether the start and termination restrictions act on the correct side of the edge, and whether idle cycles leave the metrics alone.

// File: rtl/vit_acs_pkg.sv
package vit_acs_pkg;

    localparam int unsigned SYM_CNT = 4;

    typedef enum logic [0:0] {
        ST_START = 1'b0,
        ST_RUN   = 1'b1
    } trellis_phase_e;

    // Code-bit pair carried by the branch that enters state ns from the
    // predecessor whose oldest bit is b. The shift register is {ns, b}.
    function automatic logic [1:0] branch_sym(
        input int unsigned ns,
        input int unsigned b,
        input int unsigned g0,
        input int unsigned g1
    );
        logic [31:0] shreg;
        logic        c0;
        logic        c1;
        shreg = (32'(ns) << 1) | 32'(b & 1);
        c0    = ^(shreg & 32'(g0));
        c1    = ^(shreg & 32'(g1));
        return {c0, c1};
    endfunction

endpackage

// File: rtl/vit_acs_ctrl.sv
module vit_acs_ctrl
    import vit_acs_pkg::*;
(
    input  logic           clk,
    input  logic           srst,
    input  logic           sym_valid,
    output trellis_phase_e phase_o,
    output logic           from_zero_only,
    output logic           stage_end
);

    trellis_phase_e phase_q;
    trellis_phase_e phase_d;

    // Phase register
    always_ff @(posedge clk) begin
        phase_q <= phase_d;
    end

    // Next phase and phase-dependent outputs
    always_comb begin
        phase_d        = phase_q;
        from_zero_only = 1'b0;
        unique case (phase_q)
            ST_START: begin
                from_zero_only = 1'b1;
                if (sym_valid) phase_d = ST_RUN;
            end
            ST_RUN: begin
                from_zero_only = 1'b0;
            end
            default: phase_d = ST_START;
        endcase
        if (srst) phase_d = ST_START;
    end

    assign stage_end = srst & sym_valid;
    assign phase_o   = phase_q;

    // R9: a restricted start stage hands over to unrestricted running
    p_start_to_run_r9: assert property (@(posedge clk) disable iff (srst)
        (phase_q == ST_START && sym_valid) |=> (phase_q == ST_RUN));

endmodule

// File: rtl/vit_acs_cell.sv
module vit_acs_cell #(
    parameter int PM_W = 10,
    parameter int BM_W = 4,
    parameter int PEN  = 96
) (
    input  logic [PM_W-1:0] pm_a,
    input  logic [PM_W-1:0] pm_b,
    input  logic [BM_W-1:0] bm_a,
    input  logic [BM_W-1:0] bm_b,
    input  logic            block_a,
    input  logic            block_b,
    output logic [PM_W-1:0] pm_nxt,
    output logic            pick_b
);

    logic [PM_W-1:0] cand_a;
    logic [PM_W-1:0] cand_b;
    logic [PM_W-1:0] diff;

    always_comb begin
        cand_a = block_a ? PM_W'(PEN) : pm_a + PM_W'(bm_a);
        cand_b = block_b ? PM_W'(PEN) : pm_b + PM_W'(bm_b);
        // Modular compare: the sign of the wrapped difference decides
        diff   = cand_b - cand_a;
        pick_b = diff[PM_W-1];
        pm_nxt = pick_b ? cand_b : cand_a;
    end

endmodule

// File: rtl/vit_acs_trellis.sv
module vit_acs_trellis
    import vit_acs_pkg::*;
#(
    parameter int K    = 7,
    parameter int BM_W = 4,
    parameter int G0   = 'o171,
    parameter int G1   = 'o133
) (
    input  logic                          clk,
    input  logic                          srst,
    input  logic                          sym_valid,
    input  logic [SYM_CNT*BM_W-1:0]       bm_i,
    output logic [(1<<(K-1))-1:0]         dec_o,
    output logic                          dec_valid_o
);

    localparam int N_ST = 1 << (K - 1);
    localparam int PEN  = (K - 1) << BM_W;
    localparam int PM_W = BM_W + $clog2(K - 1) + 3;

    trellis_phase_e            phase;
    logic                      from_zero_only;
    logic                      stage_end;
    logic [N_ST-1:0][PM_W-1:0] pm_q;
    logic [N_ST-1:0][PM_W-1:0] pm_nxt;
    logic [N_ST-1:0]           pick;
    logic [N_ST-1:0]           end_mask;

    vit_acs_ctrl u_ctrl (
        .clk            (clk),
        .srst           (srst),
        .sym_valid      (sym_valid),
        .phase_o        (phase),
        .from_zero_only (from_zero_only),
        .stage_end      (stage_end)
    );

    for (genvar s = 0; s < N_ST; s++) begin : g_state
        localparam int         PA    = (2 * s) % N_ST;
        localparam int         PB    = PA + 1;
        localparam logic [1:0] SYM_A = branch_sym(s, 0, G0, G1);
        localparam logic [1:0] SYM_B = branch_sym(s, 1, G0, G1);

        vit_acs_cell #(
            .PM_W (PM_W),
            .BM_W (BM_W),
            .PEN  (PEN)
        ) u_cell (
            .pm_a    (pm_q[PA]),
            .pm_b    (pm_q[PB]),
            .bm_a    (bm_i[int'(SYM_A)*BM_W +: BM_W]),
            .bm_b    (bm_i[int'(SYM_B)*BM_W +: BM_W]),
            .block_a (from_zero_only && (PA != 0)),
            .block_b (from_zero_only),
            .pm_nxt  (pm_nxt[s]),
            .pick_b  (pick[s])
        );
    end

    assign end_mask = {{(N_ST-1){~stage_end}}, 1'b1};

    // Path metrics: cleared on restart, advanced on each accepted stage
    always_ff @(posedge clk) begin
        if (srst) begin
            pm_q <= '0;
        end else if (sym_valid) begin
            pm_q <= pm_nxt;
        end
    end

    // Decision vector register
    always_ff @(posedge clk) begin
        dec_valid_o <= sym_valid;
        if (sym_valid) begin
            dec_o <= pick & end_mask;
        end
    end

    // R4: a stage yields decisions one cycle later
    p_valid_follows_r4: assert property (@(posedge clk) disable iff (srst)
        sym_valid |=> dec_valid_o);

    // R4: no stage, no decisions
    p_quiet_follows_r4: assert property (@(posedge clk) disable iff (srst)
        !sym_valid |=> !dec_valid_o);

    // R5: idle cycles leave the metrics alone
    p_hold_metrics_r5: assert property (@(posedge clk) disable iff (srst)
        !sym_valid |=> $stable(pm_q));

    // R6: the first stage after a restart only leaves state zero
    p_start_zero_r6: assert property (@(posedge clk) disable iff (srst)
        (phase == ST_START && sym_valid) |=> (dec_o == '0));

endmodule

// File: tb/vit_acs_trellis_tb.sv
`timescale 1ns/1ps
module vit_acs_trellis_tb;

    logic        clk = 1'b0;
    logic        srst = 1'b1;
    logic        sym_valid = 1'b0;
    logic [15:0] bm_i = '0;
    logic [63:0] dec_o;
    logic        dec_valid_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    longint pm_m [64];
    bit     rch  [64];

    always #2.5 clk = ~clk;

    vit_acs_trellis u_dut (
        .clk         (clk),
        .srst        (srst),
        .sym_valid   (sym_valid),
        .bm_i        (bm_i),
        .dec_o       (dec_o),
        .dec_valid_o (dec_valid_o)
    );

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            report();
        end
    end

    // R1: code-bit pair of the branch into ns from predecessor with oldest bit b
    function automatic int sym_of(int ns, int b);
        int r, c0, c1;
        r = (ns << 1) | b;
        c0 = 0; c1 = 0;
        for (int i = 0; i < 7; i++) begin
            if ((('o171 >> i) & 1) != 0) c0 ^= (r >> i) & 1;
            if ((('o133 >> i) & 1) != 0) c1 ^= (r >> i) & 1;
        end
        return c0 * 2 + c1;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < 64; s++) begin
            pm_m[s] = 0;
            rch[s]  = (s == 0);
        end
    endtask

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive inputs, predict, sample after the edge, check
    task automatic step(string tag, bit v, bit r, int b0, int b1, int b2, int b3);
        int     bm [4];
        longint npm [64];
        bit     nrch [64];
        logic [63:0] exp_d, msk;
        bm[0] = b0; bm[1] = b1; bm[2] = b2; bm[3] = b3;
        @(negedge clk);
        sym_valid = v; srst = r;
        bm_i = {4'(b3), 4'(b2), 4'(b1), 4'(b0)};
        exp_d = '0; msk = '0;
        for (int s = 0; s < 64; s++) begin
            int p0, p1;
            longint c0, c1;
            p0 = (s << 1) & 63; p1 = p0 | 1;
            c0 = pm_m[p0] + bm[sym_of(s, 0)];
            c1 = pm_m[p1] + bm[sym_of(s, 1)];
            nrch[s] = rch[p0] | rch[p1];
            npm[s] = 0;
            if (r && s != 0) begin
                msk[s] = 1'b1;
            end else if (rch[p0] && rch[p1]) begin
                msk[s] = 1'b1; exp_d[s] = (c1 < c0);
                npm[s] = (c1 < c0) ? c1 : c0;
            end else if (rch[p0]) begin
                msk[s] = 1'b1; npm[s] = c0;
            end else if (rch[p1]) begin
                msk[s] = 1'b1; exp_d[s] = 1'b1; npm[s] = c1;
            end
        end
        @(posedge clk); #1;
        check({tag, " R4 valid"}, {63'b0, dec_valid_o}, {63'b0, v});
        if (v) check(tag, dec_o & msk, exp_d);
        if (r) model_reset();
        else if (v) begin
            for (int s = 0; s < 64; s++) begin
                pm_m[s] = npm[s]; rch[s] = nrch[s];
            end
        end
    endtask

    task automatic t_reset();
        step("R8 reset idle", 0, 1, 0, 0, 0, 0);
        step("R8 reset idle", 0, 1, 0, 0, 0, 0);
        step("R8 after reset", 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_first_stage();
        step("R6 restart", 0, 1, 0, 0, 0, 0);
        step("R6 first stage", 1, 0, 15, 0, 0, 0);
        check("R6 first stage all zero", dec_o, 64'h0);
        for (int i = 0; i < 8; i++) step("R6 follow", 1, 0, 3, 9, 1, 12);
    endtask

    task automatic t_noiseless();
        int st = 0;
        step("R1 restart", 0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 40; i++) begin
            int u, ns, sy, b[4];
            u  = $urandom % 2;
            ns = (u << 5) | (st >> 1);
            sy = sym_of(ns, st & 1);
            for (int k = 0; k < 4; k++)
                b[k] = 5 * ((((k ^ sy) >> 1) & 1) + ((k ^ sy) & 1));
            step("R1 codeword", 1, 0, b[0], b[1], b[2], b[3]);
            st = ns;
        end
    endtask

    task automatic t_random();
        for (int i = 0; i < 120; i++)
            step("R2 random", 1, 0, $urandom % 16, $urandom % 16, $urandom % 16, $urandom % 16);
    endtask

    task automatic t_gap();
        for (int i = 0; i < 20; i++) begin
            step("R5 stage", 1, 0, $urandom % 16, $urandom % 16, $urandom % 16, $urandom % 16);
            step("R5 gap", 0, 0, 15, 0, 7, 3);
        end
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 300; i++)
            step("R3 wrap", 1, 0, 10 + $urandom % 6, 10 + $urandom % 6,
                 10 + $urandom % 6, 10 + $urandom % 6);
    endtask

    task automatic t_tail();
        for (int i = 0; i < 12; i++)
            step("R7 burst", 1, 0, $urandom % 16, $urandom % 16, $urandom % 16, $urandom % 16);
        step("R7 tail", 1, 1, 9, 2, 14, 0);
        step("R9 tail again", 1, 1, 0, 8, 0, 8);
        check("R9 start+end all zero", dec_o, 64'h0);
        for (int i = 0; i < 30; i++)
            step("R9 next burst", 1, 0, $urandom % 16, $urandom % 16, $urandom % 16, $urandom % 16);
    endtask

    initial begin
        model_reset();
        t_reset();
        t_first_stage();
        t_noiseless();
        t_random();
        t_gap();
        t_wrap();
        t_tail();
        report();
    end

endmodule